// File: doc/BRIEF.md
# Aliased-Width General Register File

This block holds a small set of general-purpose registers for an integer datapath. Any register can be reached as a whole word or through its low half. A fixed subset of the low-numbered registers can also be reached through their low byte. One write port and two read ports run in parallel. Each port has its own size code, so a single instruction can read a byte operand on one port and a word on the other.

A narrow write is a partial update. The bytes outside the selected width keep their old contents, so the narrow view always stays an alias of the low end of the full register. A narrow read returns the low bits widened to the full bus. A per-port flag picks zero or sign widening. A byte access to a register without a byte view is refused and reported on a flag.

A read and a write to the same register in the same cycle see the freshly merged value. A consumer that issues back-to-back dependent operations therefore needs no forwarding outside the block. By convention register 4 serves as the stack pointer and register 1 as the loop counter. Neither gets special treatment in the storage.

Top module: `alias_regfile`

## Requirements
- R1: The file holds eight 32-bit registers selected by a 3-bit index. With we high and a size code of 2'b10 or 2'b11 (word), the whole selected register takes wr_data at the clock edge.
- R2: With we low, no register changes, whatever the other write inputs carry.
- R3: A write with size code 2'b01 (half) replaces bits 15:0 of the selected register and leaves bits 31:16 unchanged.
- R4: A write with size code 2'b00 (byte) to register 0, 1, 2 or 3 replaces bits 7:0 and leaves bits 31:8 unchanged.
- R5: A byte write to register 4 to 7 leaves the register unchanged. wr_illegal is high in the cycle after such a write and low after every other cycle.
- R6: Each read port is registered. Data for the index and size presented before a clock edge appears on the port's data output after that edge. Ports A and B are independent.
- R7: A half or byte read with the sext input low zero-extends to 32 bits. With sext high it copies bit 15 (half) or bit 7 (byte) into all upper bits. A word read ignores sext.
- R8: A byte read of register 4 to 7 returns zero. The port's illegal flag is then high for that result cycle.
- R9: A read of the register being written in the same cycle returns the value after the merge, at the write's width, on either port.
- R10: A synchronous active-high reset clears all registers, both read outputs and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write enable |
| wr_sel | input | 3 | Write register index |
| wr_size | input | 2 | Write size code (00 byte, 01 half, 1x word) |
| wr_data | input | 32 | Write data, low bits used for narrow sizes |
| wr_illegal | output | 1 | Refused byte write in the previous cycle |
| ra_sel | input | 3 | Port A register index |
| ra_size | input | 2 | Port A size code |
| ra_sext | input | 1 | Port A sign-extend select |
| ra_data | output | 32 | Port A registered read data |
| ra_illegal | output | 1 | Port A refused byte read |
| rb_sel | input | 3 | Port B register index |
| rb_size | input | 2 | Port B size code |
| rb_sext | input | 1 | Port B sign-extend select |
| rb_data | output | 32 | Port B registered read data |
| rb_illegal | output | 1 | Port B refused byte read |

## Verification
The bench builds the block with its default parameters: eight 32-bit registers, 16-bit halves, 8-bit bytes and four byte-capable registers. With these values a single sequence can reach both sides of the byte boundary between registers 3 and 4. The same values put the sign bits of both narrow views within test data chosen to have them set, so zero and sign widening give different results. Stacked writes of decreasing width to one register show that each merge keeps exactly the bits above its own width.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;
endpackage

// File: rtl/arf_write_merge.sv
module arf_write_merge #(
  parameter int DATA_W    = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        size,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] merged,
  output logic              legal
);
  import arf_pkg::*;

  always_comb begin
    legal  = 1'b1;
    merged = old_val;
    unique case (size_e'(size))
      SZ_BYTE: begin
        legal  = (32'(sel) < BYTE_REGS);
        merged = {old_val[DATA_W-1:BYTE_W], wr_data[BYTE_W-1:0]};
      end
      SZ_HALF: merged = {old_val[DATA_W-1:HALF_W], wr_data[HALF_W-1:0]};
      default: merged = wr_data;
    endcase
  end
endmodule

// File: rtl/arf_read_view.sv
module arf_read_view #(
  parameter int DATA_W    = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [1:0]        size,
  input  logic              sext,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] data,
  output logic              illegal
);
  import arf_pkg::*;

  always_comb begin
    illegal = 1'b0;
    unique case (size_e'(size))
      SZ_BYTE: begin
        illegal = (32'(sel) >= BYTE_REGS);
        data = illegal ? '0 :
               {{(DATA_W-BYTE_W){sext & val[BYTE_W-1]}}, val[BYTE_W-1:0]};
      end
      SZ_HALF: data = {{(DATA_W-HALF_W){sext & val[HALF_W-1]}}, val[HALF_W-1:0]};
      default: data = val;
    endcase
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int DATA_W    = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [1:0]        ra_size,
  input  logic              ra_sext,
  output logic [DATA_W-1:0] ra_data,
  output logic              ra_illegal,
  input  logic [SEL_W-1:0]  rb_sel,
  input  logic [1:0]        rb_size,
  input  logic              rb_sext,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_illegal
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic [DATA_W-1:0] merged;
  logic              wr_legal;
  logic [DATA_W-1:0] a_view, b_view;
  logic              a_bad, b_bad;

  arf_write_merge #(
    .DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
  ) u_merge (
    .old_val(regs_q[wr_sel]), .wr_data(wr_data), .size(wr_size),
    .sel(wr_sel), .merged(merged), .legal(wr_legal)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign regs_d[i] = (we && wr_legal && wr_sel == SEL_W'(i)) ? merged : regs_q[i];
    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= '0;
      else     regs_q[i] <= regs_d[i];
    end
  end

  arf_read_view #(
    .DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
  ) u_view_a (
    .val(regs_d[ra_sel]), .size(ra_size), .sext(ra_sext),
    .sel(ra_sel), .data(a_view), .illegal(a_bad)
  );

  arf_read_view #(
    .DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
  ) u_view_b (
    .val(regs_d[rb_sel]), .size(rb_size), .sext(rb_sext),
    .sel(rb_sel), .data(b_view), .illegal(b_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data    <= '0;
      rb_data    <= '0;
      ra_illegal <= 1'b0;
      rb_illegal <= 1'b0;
      wr_illegal <= 1'b0;
    end else begin
      ra_data    <= a_view;
      rb_data    <= b_view;
      ra_illegal <= a_bad;
      rb_illegal <= b_bad;
      wr_illegal <= we && !wr_legal;
    end
  end
endmodule

// File: rtl/arf_checker.sv
module arf_checker #(
  parameter int DATA_W    = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [1:0]        wr_size,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_illegal,
  input logic [SEL_W-1:0]  ra_sel,
  input logic [1:0]        ra_size,
  input logic [DATA_W-1:0] ra_data,
  input logic [DATA_W-1:0] rb_data,
  input logic [DATA_W-1:0] regs_q [NUM_REGS]
);
  logic bad_byte_wr;
  assign bad_byte_wr = we && wr_size == 2'b00 && (32'(wr_sel) >= BYTE_REGS);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0 && !wr_illegal));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    bad_byte_wr |=> wr_illegal);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !bad_byte_wr |=> !wr_illegal);

  p_refused_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    bad_byte_wr |=> regs_q[$past(wr_sel)] == $past(regs_q[wr_sel]));

  p_half_upper_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'b01) |=>
      (regs_q[$past(wr_sel)][DATA_W-1:HALF_W] == $past(regs_q[wr_sel][DATA_W-1:HALF_W])
       && regs_q[$past(wr_sel)][HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

  p_byte_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'b00 && (32'(wr_sel) < BYTE_REGS)) |=>
      regs_q[$past(wr_sel)][DATA_W-1:BYTE_W] == $past(regs_q[wr_sel][DATA_W-1:BYTE_W]));

  p_bypass_word_r9: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size[1] && ra_sel == wr_sel && ra_size[1]) |=> ra_data == $past(wr_data));
endmodule

bind alias_regfile arf_checker #(
  .DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
  .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
) u_chk (
  .clk(clk), .rst(rst), .we(we), .wr_sel(wr_sel), .wr_size(wr_size),
  .wr_data(wr_data), .wr_illegal(wr_illegal), .ra_sel(ra_sel),
  .ra_size(ra_size), .ra_data(ra_data), .rb_data(rb_data), .regs_q(regs_q)
);

// File: tb/alias_regfile_test.sv
module alias_regfile_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [2:0] wr_sel = '0, ra_sel = '0, rb_sel = '0;
  logic [1:0] wr_size = 2'd2, ra_size = 2'd2, rb_size = 2'd2;
  logic [31:0] wr_data = '0;
  logic ra_sext = 1'b0, rb_sext = 1'b0;
  logic [31:0] ra_data, rb_data;
  logic wr_illegal, ra_illegal, rb_illegal;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alias_regfile uut (
    .clk(clk), .rst(rst), .we(we), .wr_sel(wr_sel), .wr_size(wr_size),
    .wr_data(wr_data), .wr_illegal(wr_illegal),
    .ra_sel(ra_sel), .ra_size(ra_size), .ra_sext(ra_sext),
    .ra_data(ra_data), .ra_illegal(ra_illegal),
    .rb_sel(rb_sel), .rb_size(rb_size), .rb_sext(rb_sext),
    .rb_data(rb_data), .rb_illegal(rb_illegal)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  wsel;
    logic [1:0]  wsize;
    logic [31:0] wdata;
    logic [2:0]  asel;
    logic [1:0]  asize;
    logic        asext;
    logic [2:0]  bsel;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    logic        exp_wi;
    logic        exp_ai;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd2, 2'd2, 32'h12345678, 3'd2, 2'd2, 1'b0, 3'd0, 32'h12345678, 32'h00000000, 1'b0, 1'b0},
    '{1'b1, 3'd2, 2'd1, 32'hAAAA8001, 3'd2, 2'd2, 1'b0, 3'd2, 32'h12348001, 32'h12348001, 1'b0, 1'b0},
    '{1'b1, 3'd2, 2'd0, 32'hFFFFFFC3, 3'd2, 2'd2, 1'b0, 3'd2, 32'h123480C3, 32'h123480C3, 1'b0, 1'b0},
    '{1'b0, 3'd0, 2'd2, 32'h00000000, 3'd2, 2'd1, 1'b1, 3'd5, 32'hFFFF80C3, 32'h00000000, 1'b0, 1'b0},
    '{1'b0, 3'd0, 2'd2, 32'h00000000, 3'd2, 2'd1, 1'b0, 3'd5, 32'h000080C3, 32'h00000000, 1'b0, 1'b0},
    '{1'b0, 3'd0, 2'd2, 32'h00000000, 3'd2, 2'd0, 1'b1, 3'd5, 32'hFFFFFFC3, 32'h00000000, 1'b0, 1'b0},
    '{1'b0, 3'd0, 2'd2, 32'h00000000, 3'd2, 2'd0, 1'b0, 3'd5, 32'h000000C3, 32'h00000000, 1'b0, 1'b0},
    '{1'b1, 3'd5, 2'd2, 32'hCAFEF00D, 3'd5, 2'd2, 1'b0, 3'd5, 32'hCAFEF00D, 32'hCAFEF00D, 1'b0, 1'b0},
    '{1'b1, 3'd5, 2'd0, 32'h00000011, 3'd5, 2'd2, 1'b0, 3'd5, 32'hCAFEF00D, 32'hCAFEF00D, 1'b1, 1'b0},
    '{1'b0, 3'd0, 2'd2, 32'h00000000, 3'd5, 2'd0, 1'b0, 3'd2, 32'h00000000, 32'h123480C3, 1'b0, 1'b1},
    '{1'b1, 3'd4, 2'd1, 32'h00001234, 3'd4, 2'd2, 1'b0, 3'd4, 32'h00001234, 32'h00001234, 1'b0, 1'b0},
    '{1'b1, 3'd0, 2'd0, 32'h0000007F, 3'd0, 2'd1, 1'b1, 3'd0, 32'h0000007F, 32'h0000007F, 1'b0, 1'b0},
    '{1'b1, 3'd7, 2'd3, 32'h89ABCDEF, 3'd7, 2'd2, 1'b1, 3'd6, 32'h89ABCDEF, 32'h00000000, 1'b0, 1'b0},
    '{1'b0, 3'd1, 2'd2, 32'h0000DEAD, 3'd1, 2'd2, 1'b0, 3'd1, 32'h00000000, 32'h00000000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: state right after reset
    chk("R10 ra_data after reset", ra_data, 32'h0);
    chk("R10 rb_data after reset", rb_data, 32'h0);
    chk("R10 flags after reset", {29'h0, wr_illegal, ra_illegal, rb_illegal}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: vector table, result sampled after the edge
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      we = VEC[k].we; wr_sel = VEC[k].wsel; wr_size = VEC[k].wsize; wr_data = VEC[k].wdata;
      ra_sel = VEC[k].asel; ra_size = VEC[k].asize; ra_sext = VEC[k].asext;
      rb_sel = VEC[k].bsel; rb_size = 2'd2; rb_sext = 1'b0;
      @(posedge clk);
      #1;
      chk($sformatf("R9 R7 port A row %0d", k), ra_data, VEC[k].exp_a);
      chk($sformatf("R6 port B row %0d", k), rb_data, VEC[k].exp_b);
      chk($sformatf("R5 wr_illegal row %0d", k), {31'h0, wr_illegal}, {31'h0, VEC[k].exp_wi});
      chk($sformatf("R8 ra_illegal row %0d", k), {31'h0, ra_illegal}, {31'h0, VEC[k].exp_ai});
    end

    // R8: byte read of register 6 on port B
    @(negedge clk);
    we = 1'b0; rb_sel = 3'd6; rb_size = 2'd0; rb_sext = 1'b1;
    ra_sel = 3'd2; ra_size = 2'd2; ra_sext = 1'b0;
    @(posedge clk);
    #1;
    chk("R8 rb_illegal on byte read of r6", {31'h0, rb_illegal}, 32'h1);
    chk("R8 rb_data zero on refused read", rb_data, 32'h0);
    chk("R6 port A independent of port B", ra_data, 32'h123480C3);

    // R10: mid-run reset clears every register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; rb_size = 2'd2; rb_sext = 1'b0;
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      ra_sel = 3'(r); ra_size = 2'd2;
      @(posedge clk);
      #1;
      chk($sformatf("R10 register %0d cleared", r), ra_data, 32'h0);
    end
    finish_run();
  end
endmodule